// File: doc/BRIEF.md
# Instruction Breakpoint and Vector-Catch Checker

This block sits beside an instruction pipeline and decides, for each instruction that passes its check stage, whether that instruction should raise a breakpoint event or a vector-catch event. It compares every addressable unit that the instruction covers against a small bank of address breakpoints. It also compares those units against the exception vector addresses selected by a vector-catch enable field. The size of a unit follows the instruction-set state: four bytes, two bytes or one byte.

A match is recorded as a mark on the instruction at check time. The event itself is reported only in the cycle in which the marked instruction reaches execute. At that point the event is dropped if debug is not permitted, or if a flush arrives. Interrupt entry can supply the IRQ and FIQ handler addresses. These are held in capture registers, and in vectored mode the IRQ and FIQ catches compare against the captured addresses.

Top module: `insn_bkpt_catch`

## Requirements
- R1: When `dbg_mode` is 2'b00 at check time, the instruction is not marked and no event follows from it.
- R2: The unit size follows `chk_iset`: 0 means 4 bytes, 1 and 2 mean 2 bytes, and 3 means 1 byte.
- R3: The number of units checked is `chk_len` divided by the unit size, rounded down. Unit k sits at `chk_addr + k*size`. Breakpoint j hits a unit when `bp_en[j]` is set, address bits [31:2] are equal, and bit `addr[1:0]` of the 4-bit mask `bp_bsel[4j+3:4j]` is set.
- R4: An event is a pulse that is high only in a cycle with `ex_valid` high while a mark is pending. A mark is consumed by that cycle, so a second `ex_valid` raises nothing.
- R5: When `dbg_permit` is low in the execute cycle, the mark is discarded and no event is raised.
- R6: Bits 0 to 6 of `vc_en` catch the vector at offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x18 and 0x1C from `vec_base`.
- R7: When `vec_mode` is 1, bits 5 and 6 compare against the addresses captured on the most recent `irq_taken` and `fiq_taken` strobes. Each strobe replaces the captured address.
- R8: When one instruction hits both a breakpoint and a vector catch, only `bp_evt` is raised.
- R9: A `flush` clears any pending mark. No event is raised in the flush cycle or for the flushed instruction afterwards.
- R10: After reset, both event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chk_valid | input | 1 | Instruction present at check stage |
| chk_addr | input | AW | Instruction address |
| chk_len | input | LW | Instruction length in bytes |
| chk_iset | input | 2 | Instruction-set state |
| dbg_mode | input | 2 | Debug mode field, 00 = off |
| bp_addr | input | NBP*AW | Breakpoint addresses, packed |
| bp_en | input | NBP | Breakpoint enables |
| bp_bsel | input | NBP*4 | Breakpoint byte-lane masks |
| vc_en | input | 7 | Vector-catch enables |
| vec_base | input | AW | Exception vector base |
| vec_mode | input | 1 | Use captured IRQ/FIQ addresses |
| irq_taken | input | 1 | IRQ entry strobe |
| irq_vec | input | AW | IRQ handler address |
| fiq_taken | input | 1 | FIQ entry strobe |
| fiq_vec | input | AW | FIQ handler address |
| ex_valid | input | 1 | Marked instruction reaches execute |
| dbg_permit | input | 1 | Debug events permitted now |
| flush | input | 1 | Discard pending mark |
| bp_evt | output | 1 | Breakpoint event pulse |
| vc_evt | output | 1 | Vector-catch event pulse |

## Verification
The main sweep walks a byte-granular address window around a set of breakpoints. It covers every instruction-set state and several lengths. This separates unit step size, unit count, byte-mask lanes and disabled registers, because an off-by-one in the unit loop moves the hit to a neighbouring address. Directed cases place instructions on each class of vector address, plain and vectored. They also change a captured address to show that the old one stops matching. Other cases combine a breakpoint with a catch to check priority. Timing cases delay execute, repeat it, drop permission or flush, to separate the marking step from the signalling step.

// File: rtl/insn_bkpt_catch.sv
module insn_bkpt_catch #(
  parameter int NBP    = 4,
  parameter int AW     = 32,
  parameter int MAXLEN = 4,
  parameter int LW     = $clog2(MAXLEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_valid,
  input  logic [AW-1:0]    chk_addr,
  input  logic [LW-1:0]    chk_len,
  input  logic [1:0]       chk_iset,
  input  logic [1:0]       dbg_mode,
  input  logic [NBP*AW-1:0] bp_addr,
  input  logic [NBP-1:0]   bp_en,
  input  logic [NBP*4-1:0] bp_bsel,
  input  logic [6:0]       vc_en,
  input  logic [AW-1:0]    vec_base,
  input  logic             vec_mode,
  input  logic             irq_taken,
  input  logic [AW-1:0]    irq_vec,
  input  logic             fiq_taken,
  input  logic [AW-1:0]    fiq_vec,
  input  logic             ex_valid,
  input  logic             dbg_permit,
  input  logic             flush,
  output logic             bp_evt,
  output logic             vc_evt
);
  localparam int NVC = 7;

  logic [1:0]    sh;
  logic [LW-1:0] units;
  logic [AW-1:0] irq_cap, fiq_cap;
  logic [AW-1:0] ua [MAXLEN];
  logic [AW-1:0] vaddr [NVC];
  logic [MAXLEN-1:0] bp_u, vc_u;
  logic          pend_bp, pend_vc;
  logic          hit_bp, hit_vc;

  assign sh    = (chk_iset == 2'd0) ? 2'd2 : (chk_iset == 2'd3) ? 2'd0 : 2'd1;
  assign units = chk_len >> sh;

  for (genvar i = 0; i < NVC; i++) begin : g_vec
    localparam int OFF = (i < 5) ? i * 4 : i * 4 + 4;
    if (i == 5) begin : g_irq
      assign vaddr[i] = vec_mode ? irq_cap : vec_base + AW'(OFF);
    end else if (i == 6) begin : g_fiq
      assign vaddr[i] = vec_mode ? fiq_cap : vec_base + AW'(OFF);
    end else begin : g_fix
      assign vaddr[i] = vec_base + AW'(OFF);
    end
  end

  for (genvar k = 0; k < MAXLEN; k++) begin : g_unit
    logic [NBP-1:0] bm;
    logic [NVC-1:0] vm;
    assign ua[k] = chk_addr + (AW'(k) << sh);
    for (genvar j = 0; j < NBP; j++) begin : g_bp
      assign bm[j] = bp_en[j] && (ua[k][AW-1:2] == bp_addr[j*AW+2 +: AW-2])
                     && bp_bsel[j*4 + int'(ua[k][1:0])];
    end
    for (genvar i = 0; i < NVC; i++) begin : g_vc
      assign vm[i] = vc_en[i] && (ua[k] == vaddr[i]);
    end
    assign bp_u[k] = (LW'(k) < units) && |bm;
    assign vc_u[k] = (LW'(k) < units) && |vm;
  end

  assign hit_bp = chk_valid && (dbg_mode != 2'b00) && |bp_u;
  assign hit_vc = chk_valid && (dbg_mode != 2'b00) && |vc_u;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_cap <= '0;
      fiq_cap <= '0;
    end else begin
      if (irq_taken) irq_cap <= irq_vec;
      if (fiq_taken) fiq_cap <= fiq_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_bp <= 1'b0;
      pend_vc <= 1'b0;
    end else if (flush) begin
      pend_bp <= 1'b0;
      pend_vc <= 1'b0;
    end else if (chk_valid) begin
      pend_bp <= hit_bp;
      pend_vc <= hit_vc;
    end else if (ex_valid) begin
      pend_bp <= 1'b0;
      pend_vc <= 1'b0;
    end
  end

  assign bp_evt = ex_valid && dbg_permit && !flush && pend_bp;
  assign vc_evt = ex_valid && dbg_permit && !flush && pend_vc && !pend_bp;
endmodule

module insn_bkpt_catch_chk (
  input logic clk,
  input logic rst_n,
  input logic ex_valid,
  input logic dbg_permit,
  input logic flush,
  input logic bp_evt,
  input logic vc_evt
);
  // R8
  excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bp_evt && vc_evt));
  // R4
  evt_at_ex_chk: assert property (@(posedge clk) disable iff (!rst_n) (bp_evt || vc_evt) |-> ex_valid);
  // R5
  permit_chk: assert property (@(posedge clk) disable iff (!rst_n) !dbg_permit |-> !(bp_evt || vc_evt));
  // R9
  flush_now_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |-> !(bp_evt || vc_evt));
  // R9
  flush_next_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !(bp_evt || vc_evt));
endmodule

bind insn_bkpt_catch insn_bkpt_catch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .dbg_permit(dbg_permit),
  .flush(flush), .bp_evt(bp_evt), .vc_evt(vc_evt)
);

// File: tb/insn_bkpt_catch_test.sv
`timescale 1ns/100ps
module insn_bkpt_catch_test;
  logic clk = 0, rst_n = 0;
  logic chk_valid = 0;
  logic [31:0] chk_addr = 0;
  logic [2:0]  chk_len = 0;
  logic [1:0]  chk_iset = 0, dbg_mode = 2'b01;
  logic [127:0] bp_addr = 0;
  logic [3:0]  bp_en = 0;
  logic [15:0] bp_bsel = 0;
  logic [6:0]  vc_en = 0;
  logic [31:0] vec_base = 0, irq_vec = 0, fiq_vec = 0;
  logic vec_mode = 0, irq_taken = 0, fiq_taken = 0;
  logic ex_valid = 0, dbg_permit = 1, flush = 0;
  logic bp_evt, vc_evt;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  insn_bkpt_catch uut (.*);

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got bp,vc=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [2:0] l, input logic [1:0] s);
    @(negedge clk);
    chk_valid = 1; chk_addr = a; chk_len = l; chk_iset = s;
    @(negedge clk);
    chk_valid = 0;
  endtask

  task automatic run(input string req, input logic [31:0] a, input logic [2:0] l,
                     input logic [1:0] s, input logic [1:0] exp);
    issue(a, l, s);
    ex_valid = 1;
    #1 chk(req, {bp_evt, vc_evt}, exp);
    @(negedge clk);
    ex_valid = 0;
  endtask

  function automatic logic model_bp(input logic [31:0] a, input int l, input int s);
    int step = (s == 0) ? 4 : (s == 3) ? 1 : 2;
    for (int k = 0; k < l / step; k++) begin
      logic [31:0] u = a + k * step;
      for (int j = 0; j < 4; j++)
        if (bp_en[j] && u[31:2] == bp_addr[j*32+2 +: 30] && bp_bsel[j*4 + u[1:0]])
          return 1'b1;
    end
    return 1'b0;
  endfunction

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 chk("R10", {bp_evt, vc_evt}, 2'b00);
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R10", {bp_evt, vc_evt}, 2'b00);

    bp_addr[31:0] = 32'h1000; bp_bsel[3:0] = 4'b0100; bp_en[0] = 1;
    bp_addr[63:32] = 32'h1004; bp_bsel[7:4] = 4'b0001; bp_en[1] = 1;
    bp_addr[95:64] = 32'h1008; bp_bsel[11:8] = 4'b1111; bp_en[2] = 0;
    // R2 R3 sweep
    for (int a = 32'hFF8; a <= 32'h100C; a++)
      for (int s = 0; s < 4; s++)
        for (int li = 0; li < 3; li++) begin
          int l = (li == 0) ? 1 : (li == 1) ? 2 : 4;
          run("R3", a, 3'(l), 2'(s), {model_bp(a, l, s), 1'b0});
        end

    // R1
    dbg_mode = 2'b00;
    run("R1", 32'h1002, 3'd1, 2'd3, 2'b00);
    dbg_mode = 2'b10;
    run("R1", 32'h1002, 3'd1, 2'd3, 2'b10);

    // R4 delayed execute, then repeated execute
    issue(32'h1004, 3'd4, 2'd0);
    #1 chk("R4", {bp_evt, vc_evt}, 2'b00);
    @(negedge clk); ex_valid = 1;
    #1 chk("R4", {bp_evt, vc_evt}, 2'b10);
    @(negedge clk);
    #1 chk("R4", {bp_evt, vc_evt}, 2'b00);
    @(negedge clk); ex_valid = 0;

    // R5
    dbg_permit = 0;
    run("R5", 32'h1004, 3'd4, 2'd0, 2'b00);
    dbg_permit = 1;

    // R9
    issue(32'h1004, 3'd4, 2'd0);
    ex_valid = 1; flush = 1;
    #1 chk("R9", {bp_evt, vc_evt}, 2'b00);
    @(negedge clk); flush = 0;
    #1 chk("R9", {bp_evt, vc_evt}, 2'b00);
    @(negedge clk); ex_valid = 0;

    // R6
    vec_base = 32'hFFFF0000;
    vc_en = 7'b0000100;
    run("R6", 32'hFFFF0008, 3'd4, 2'd0, 2'b01);
    vc_en = 7'b0010000;
    run("R6", 32'hFFFF0010, 3'd4, 2'd0, 2'b01);
    run("R6", 32'hFFFF000C, 3'd4, 2'd0, 2'b00);
    vc_en = 7'b1100000;
    run("R6", 32'hFFFF0018, 3'd4, 2'd0, 2'b01);
    run("R6", 32'hFFFF001C, 3'd2, 2'd1, 2'b01);
    run("R6", 32'hFFFF0014, 3'd4, 2'd0, 2'b00);

    // R8
    vc_en = 7'b0000100;
    bp_addr[127:96] = 32'hFFFF0008; bp_bsel[15:12] = 4'b0001; bp_en[3] = 1;
    run("R8", 32'hFFFF0008, 3'd4, 2'd0, 2'b10);
    bp_en[3] = 0;

    // R7
    @(negedge clk); irq_taken = 1; irq_vec = 32'h2000;
    fiq_taken = 1; fiq_vec = 32'h3002;
    @(negedge clk); irq_taken = 0; fiq_taken = 0;
    vec_mode = 1; vc_en = 7'b1100000;
    run("R7", 32'h2000, 3'd4, 2'd0, 2'b01);
    run("R7", 32'hFFFF0018, 3'd4, 2'd0, 2'b00);
    run("R7", 32'h3000, 3'd4, 2'd1, 2'b01);
    run("R7", 32'h3000, 3'd2, 2'd1, 2'b00);
    @(negedge clk); irq_taken = 1; irq_vec = 32'h2100;
    @(negedge clk); irq_taken = 0;
    run("R7", 32'h2000, 3'd4, 2'd0, 2'b00);
    run("R7", 32'h2100, 3'd1, 2'd3, 2'b01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule